// File: doc/BRIEF.md
# Encoded Interrupt Level Mask Unit

This block gates interrupt requests that reach it as 4-bit encoded levels on two independent pin groups. Group 0 is the lower pin group and group 1 the upper. Each of the fifteen requesting levels of each group has its own mask bit. The all-high code (15) means that no request is present, so it has no mask bit.

Software sets mask bits by writing ones through a set port and removes them by writing ones through a separate clear port. A zero written to either port leaves the bits unchanged. Both ports act on the same 32-bit layout, and a read returns the mask state currently in force.

Each group looks up the mask bit for its present level and either forwards the request or suppresses it. The level is passed on unchanged. A group's masks count only while that group is in encoded mode and a higher-level mask does not already block the whole group.

Top module: `lvl_mask_unit`

## Requirements
- R1: After reset, every mask bit is 0 and `rd_data` reads 0.
- R2: When `set_we` is high, each bit of `set_data` that is 1 sets its mask bit at the next clock edge.
- R3: A mask bit whose set and clear bits are both 0 in a cycle keeps its value. This includes cycles with `set_we` or `clr_we` high.
- R4: When `clr_we` is high, each bit of `clr_data` that is 1 clears its mask bit at the next clock edge.
- R5: When one cycle both sets and clears the same bit, the bit ends up cleared.
- R6: Bits 16 and 0 of `rd_data` always read 0, even after ones are written to them.
- R7: Group 0 level p is masked by bit 31-p, and group 1 level p is masked by bit 15-p, for p = 0 to 14. In `rd_data`, 1 means masked and 0 means accepted.
- R8: `req_out[g]` is 1 when all of the following hold: level g is not 15, `grp_enc_en[g]` is 1, `grp_hi_mask[g]` is 0, and the level's mask bit is 0. In the same cycle, `lvl_out` carries `lvl_in` for that group unchanged.
- R9: Level 15 never raises `req_out`.
- R10: A group with `grp_enc_en` low or `grp_hi_mask` high raises no request.
- R11: The mask value read back in the cycle after a write is the value that gates the requests in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 32 | Ones select the mask bits to set |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 32 | Ones select the mask bits to clear |
| rd_data | output | 32 | Mask state currently in force |
| lvl_in | input | 8 | Encoded level: [3:0] group 0, [7:4] group 1 |
| grp_enc_en | input | 2 | Per-group encoded mode enable |
| grp_hi_mask | input | 2 | Per-group mask from the higher mask register |
| req_out | output | 2 | Per-group request after masking |
| lvl_out | output | 8 | Forwarded level, same layout as lvl_in |

## Verification
The bench builds the block with the default parameters: a 4-bit level and two groups. These give the full 32-bit layout, both reserved bit positions and every one of the thirty level-to-bit mappings.

With this configuration, the bench can sweep all sixteen codes on both groups against fixed mask patterns. It also covers set and clear in the same cycle, and zero-valued writes. A random phase mixes writes, enables and group masks.

// File: rtl/lvl_mask_pkg.sv
package lvl_mask_pkg;
  // Position of the mask bit for level pat of group grp in the register word.
  function automatic int bit_pos(input int grp, input int pat, input int slots, input int dw);
    return dw - 1 - grp * slots - pat;
  endfunction
endpackage

// File: rtl/mask_bank.sv
module mask_bank
  import lvl_mask_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int NGRP  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   set_we,
  input  logic [NGRP*(1<<LVL_W)-1:0]             set_data,
  input  logic                                   clr_we,
  input  logic [NGRP*(1<<LVL_W)-1:0]             clr_data,
  output logic [NGRP-1:0][(1<<LVL_W)-2:0]        mask_q,
  output logic [NGRP*(1<<LVL_W)-1:0]             rd_data
);
  localparam int SLOTS = 1 << LVL_W;
  localparam int NPAT  = SLOTS - 1;
  localparam int DW    = NGRP * SLOTS;

  logic [NGRP-1:0][NPAT-1:0] mask_d;
  logic [NGRP-1:0][NPAT-1:0] mask_en;

  // next-state: clear wins over set
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      for (int p = 0; p < NPAT; p++) begin
        mask_en[g][p] = (set_we & set_data[bit_pos(g, p, SLOTS, DW)]) |
                        (clr_we & clr_data[bit_pos(g, p, SLOTS, DW)]);
        mask_d[g][p]  = ~(clr_we & clr_data[bit_pos(g, p, SLOTS, DW)]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        for (int p = 0; p < NPAT; p++) begin
          if (mask_en[g][p]) mask_q[g][p] <= mask_d[g][p];
        end
      end
    end
  end

  // read-back: reserved positions stay 0
  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int p = 0; p < NPAT; p++) begin
        rd_data[bit_pos(g, p, SLOTS, DW)] = mask_q[g][p];
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk_grp
    for (genvar p = 0; p < NPAT; p++) begin : g_chk_pat
      localparam int BP = bit_pos(g, p, SLOTS, DW);
      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && set_data[BP] && !(clr_we && clr_data[BP])) |=> mask_q[g][p]);
      p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_data[BP]) |=> !mask_q[g][p]);
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(set_we && set_data[BP]) && !(clr_we && clr_data[BP])) |=> $stable(mask_q[g][p]));
    end
  end
endmodule

// File: rtl/lvl_gate.sv
module lvl_gate #(
  parameter int LVL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LVL_W-1:0]        lvl,
  input  logic                    enc_en,
  input  logic                    hi_mask,
  input  logic [(1<<LVL_W)-2:0]   mask_vec,
  output logic                    req,
  output logic [LVL_W-1:0]        lvl_fwd
);
  localparam int NPAT = (1 << LVL_W) - 1;
  localparam logic [LVL_W-1:0] IDLE = '1;

  logic is_idle;
  logic lvl_masked;

  always_comb begin
    is_idle    = (lvl == IDLE);
    lvl_masked = 1'b1;
    for (int p = 0; p < NPAT; p++) begin
      if (lvl == p[LVL_W-1:0]) lvl_masked = mask_vec[p];
    end
    req     = !is_idle && enc_en && !hi_mask && !lvl_masked;
    lvl_fwd = lvl;
  end

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == IDLE) |-> !req);
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_en || hi_mask) |-> !req);
endmodule

// File: rtl/lvl_mask_unit.sv
module lvl_mask_unit
  import lvl_mask_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int NGRP  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_we,
  input  logic [NGRP*(1<<LVL_W)-1:0]  set_data,
  input  logic                        clr_we,
  input  logic [NGRP*(1<<LVL_W)-1:0]  clr_data,
  output logic [NGRP*(1<<LVL_W)-1:0]  rd_data,
  input  logic [NGRP*LVL_W-1:0]       lvl_in,
  input  logic [NGRP-1:0]             grp_enc_en,
  input  logic [NGRP-1:0]             grp_hi_mask,
  output logic [NGRP-1:0]             req_out,
  output logic [NGRP*LVL_W-1:0]       lvl_out
);
  localparam int SLOTS = 1 << LVL_W;
  localparam int NPAT  = SLOTS - 1;
  localparam int DW    = NGRP * SLOTS;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NGRP-1:0][NPAT-1:0] mask_q;

  mask_bank #(.LVL_W(LVL_W), .NGRP(NGRP)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .mask_q   (mask_q),
    .rd_data  (rd_data)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    lvl_gate #(.LVL_W(LVL_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .lvl      (lvl_in[g*LVL_W +: LVL_W]),
      .enc_en   (grp_enc_en[g]),
      .hi_mask  (grp_hi_mask[g]),
      .mask_vec (mask_q[g]),
      .req      (req_out[g]),
      .lvl_fwd  (lvl_out[g*LVL_W +: LVL_W])
    );
    localparam int RSV = bit_pos(g, NPAT, SLOTS, DW);
    p_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !rd_data[RSV]);
    p_fwd_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      lvl_out[g*LVL_W +: LVL_W] == lvl_in[g*LVL_W +: LVL_W]);
  end
endmodule

// File: tb/sim_lvl_mask_unit.sv
module sim_lvl_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        set_we, clr_we;
  logic [31:0] set_data, clr_data, rd_data;
  logic [7:0]  lvl_in, lvl_out;
  logic [1:0]  grp_enc_en, grp_hi_mask, req_out;

  int n_chk = 0;
  int n_fail = 0;
  bit [31:0] mdl;

  always #5 clk = ~clk;

  lvl_mask_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .rd_data(rd_data),
    .lvl_in(lvl_in), .grp_enc_en(grp_enc_en), .grp_hi_mask(grp_hi_mask),
    .req_out(req_out), .lvl_out(lvl_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare all outputs with the reference model
  task automatic compare(input string tag);
    chk({tag, " rd_data"}, rd_data, mdl);
    for (int g = 0; g < 2; g++) begin
      int lv;
      bit er;
      lv = int'(lvl_in[g*4 +: 4]);
      er = (lv != 15) && grp_enc_en[g] && !grp_hi_mask[g] && !mdl[31 - 16*g - lv];
      chk({tag, " R8 req"}, {31'd0, req_out[g]}, {31'd0, er});
      chk({tag, " R8 lvl_out"}, {28'd0, lvl_out[g*4 +: 4]}, {28'd0, lvl_in[g*4 +: 4]});
    end
  endtask

  task automatic step(input string tag, input bit sw, input logic [31:0] sd,
                      input bit cw, input logic [31:0] cd);
    @(negedge clk);
    set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
    @(posedge clk);
    if (sw) mdl = mdl | (sd & 32'hFFFE_FFFE);
    if (cw) mdl = mdl & ~cd;
    #1;
    compare(tag);
    @(negedge clk);
    set_we = 1'b0; clr_we = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      lvl_in = {4'(15 - a), 4'(a)};
      #1;
      compare(tag);
    end
  endtask

  initial begin
    rst_n = 1'b0; set_we = 0; clr_we = 0; set_data = 0; clr_data = 0;
    lvl_in = 8'h00; grp_enc_en = 2'b11; grp_hi_mask = 2'b00; mdl = 0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    compare("R1 after release");
    sweep("R1 R8 all accepted");

    step("R2 set one bit", 1, 32'h8000_0000, 0, 0);
    step("R7 upper group bit", 1, 32'h0000_4000, 0, 0);
    sweep("R7 R8 mapping");
    step("R3 zero write set", 1, 32'h0, 0, 0);
    step("R3 zero write clear", 0, 0, 1, 32'h0);
    step("R6 all ones", 1, 32'hFFFF_FFFF, 0, 0);
    chk("R6 reserved bits", rd_data & 32'h0001_0001, 32'h0);
    sweep("R11 all masked");
    step("R4 clear some", 1'b0, 0, 1, 32'h5555_5555);
    sweep("R7 R11 pattern");
    step("R5 set and clear", 1, 32'h0F0F_0F0F, 1, 32'h0303_0303);
    chk("R5 bit cleared", rd_data & 32'h0303_0303, 32'h0);
    step("R3 other bits hold", 1, 32'h0000_0000, 1, 32'h0000_0000);

    step("R4 clear all", 0, 0, 1, 32'hFFFF_FFFF);
    @(negedge clk) grp_enc_en = 2'b10;
    sweep("R10 group0 disabled");
    @(negedge clk) begin grp_enc_en = 2'b11; grp_hi_mask = 2'b10; end
    sweep("R10 group1 hi masked");
    @(negedge clk) grp_hi_mask = 2'b00;
    @(negedge clk) lvl_in = 8'hFF;
    #1;
    compare("R9 idle level");

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lvl_in = 8'($urandom);
      grp_enc_en = 2'($urandom);
      grp_hi_mask = 2'($urandom);
      step("R2 R3 R4 R5 R11 random", 1'($urandom), $urandom, 1'($urandom), $urandom & $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule